// File: doc/BRIEF.md
# Receive completion entry generator

This block produces one 32-bit completion record for every frame the receive path finishes. A frame-done strobe arrives with the byte count, a MAC error flag and a 16-bit checksum. The block packs these into a record, writes the record into its own completion memory at the slot the producer index selects, and then advances the 16-bit producer index. Software reads records through a read port. It hands slots back by moving a 16-bit consumer index. One cycle after each write, a single-cycle receive event pulse tells the interrupt logic that a new record is ready.

Each record carries a valid bit. Its sense starts at 1 and inverts on every pass around the ring, so software can tell new records from stale ones without clearing memory. The ring size is set by software as a base-2 logarithm. When the ring holds a full ring's worth of unconsumed records, an arriving frame leaves no record and a drop counter increments instead.

Top module: `rx_cmpl_gen`

## Requirements
- R1: A record packs the length in bits 10:0, the valid bit in bit 11, the MAC error flag in bit 12, the truncation flag in bit 13, zeros in bits 15:14, and the checksum in bits 31:16.
- R2: A frame whose length exceeds 2047 bytes is recorded with length 2047 and bit 13 set. A frame of 2047 bytes or less is recorded with its exact length and bit 13 clear.
- R3: The ring holds 2^lg entries, where lg is `ring_lg_i` clamped to the range 5..10. A record is written at address (producer index) mod (ring size).
- R4: The valid bit of a record equals the current polarity. Polarity is 1 after reset and inverts after a record is written into the last slot of the ring.
- R5: When (producer − consumer) mod 2^16 is equal to or greater than the ring size, an arriving frame produces no write. The producer index and polarity do not change, memory is untouched, and the drop counter increments by one.
- R6: The producer index is 0 after reset. It increments by one for each written record and wraps modulo 2^16.
- R7: The write port is asserted in the cycle after a frame-done strobe is sampled. The record can be read at the read port from the following cycle.
- R8: `rx_event_o` is a one-cycle pulse asserted in the cycle after each cycle in which `wr_en_o` is high, and at no other time.
- R9: After reset, `wr_en_o`, `rx_event_o`, `prod_idx_o` and `drop_cnt_o` are all zero.
- R10: Frame-done strobes on consecutive cycles each produce their own record, or their own drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_done_i | input | 1 | One-cycle strobe marking a finished frame |
| frame_len_i | input | 16 | Received frame length in bytes |
| frame_mac_err_i | input | 1 | MAC reported an error on the frame |
| frame_csum_i | input | 16 | Frame checksum |
| ring_lg_i | input | 4 | log2 of the ring size, clamped to 5..10 |
| cons_idx_i | input | 16 | Software consumer index |
| rd_addr_i | input | 10 | Completion memory read address |
| rd_data_o | output | 32 | Completion memory read data (combinational) |
| wr_en_o | output | 1 | Record write strobe |
| wr_addr_o | output | 10 | Record write slot |
| wr_data_o | output | 32 | Record being written |
| prod_idx_o | output | 16 | Hardware producer index |
| drop_cnt_o | output | 16 | Count of frames dropped on a full ring |
| rx_event_o | output | 1 | Receive event pulse |

## Verification
The bench fills a 32-entry ring to the limit and pushes frames past it. A wrong full test would either overwrite slot 0, which the read port then exposes, or stall one entry early. It runs the ring through two passes to show the valid bit inverting exactly at the wrap, and sends lengths of 2047, 2048 and 3000 to expose an off-by-one truncation threshold. It programs log values below and above the legal range, where a missing clamp would change the drop point. A final run of 65536 frames takes the producer index through its 16-bit wrap, where a wrong occupancy subtraction would report a full ring.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  localparam int LEN_W   = 11;
  localparam int CSUM_W  = 16;
  localparam int ENTRY_W = 32;

  typedef struct packed {
    logic [CSUM_W-1:0] csum;
    logic [1:0]        rsvd;
    logic              trunc;
    logic              mac_err;
    logic              valid;
    logic [LEN_W-1:0]  len;
  } cmpl_entry_t;
endpackage

// File: rtl/rxc_pack.sv
module rxc_pack
  import rxc_pkg::*;
#(
  parameter int IN_LEN_W = 16
) (
  input  logic [IN_LEN_W-1:0] len_i,
  input  logic                mac_err_i,
  input  logic [CSUM_W-1:0]   csum_i,
  input  logic                pol_i,
  output cmpl_entry_t         entry_o
);
  localparam int MAX_LEN = (1 << LEN_W) - 1;

  logic too_long;
  assign too_long = len_i > IN_LEN_W'(MAX_LEN);

  always_comb begin
    entry_o.csum    = csum_i;
    entry_o.rsvd    = 2'b00;
    entry_o.trunc   = too_long;
    entry_o.mac_err = mac_err_i;
    entry_o.valid   = pol_i;
    entry_o.len     = too_long ? LEN_W'(MAX_LEN) : len_i[LEN_W-1:0];
  end
endmodule

// File: rtl/rxc_ring_ctl.sv
module rxc_ring_ctl #(
  parameter int MIN_LG = 5,
  parameter int MAX_LG = 10,
  parameter int LG_W   = 4,
  parameter int IDX_W  = 16,
  localparam int ADDR_W = MAX_LG
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_done_i,
  input  logic [LG_W-1:0]   ring_lg_i,
  input  logic [IDX_W-1:0]  cons_idx_i,
  output logic              accept_o,
  output logic [ADDR_W-1:0] slot_o,
  output logic              pol_o,
  output logic [IDX_W-1:0]  prod_idx_o,
  output logic [IDX_W-1:0]  drop_cnt_o
);
  logic [LG_W-1:0]  lg_eff;
  logic [IDX_W:0]   size;
  logic [IDX_W-1:0] mask, occ;
  logic             full, last_slot;
  logic [IDX_W-1:0] prod_q, drop_q;
  logic             pol_q;

  always_comb begin
    if (ring_lg_i < LG_W'(MIN_LG))      lg_eff = LG_W'(MIN_LG);
    else if (ring_lg_i > LG_W'(MAX_LG)) lg_eff = LG_W'(MAX_LG);
    else                                lg_eff = ring_lg_i;
  end

  assign size      = (IDX_W+1)'(1) << lg_eff;
  assign mask      = size[IDX_W-1:0] - IDX_W'(1);
  assign occ       = prod_q - cons_idx_i;
  // >= rather than == keeps a bad consumer index from reopening the ring
  assign full      = {1'b0, occ} >= size;
  assign accept_o  = frame_done_i & ~full;
  assign slot_o    = prod_q[ADDR_W-1:0] & mask[ADDR_W-1:0];
  assign last_slot = slot_o == mask[ADDR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q <= '0;
      drop_q <= '0;
      pol_q  <= 1'b1;
    end else if (accept_o) begin
      prod_q <= prod_q + IDX_W'(1);
      if (last_slot) pol_q <= ~pol_q;
    end else if (frame_done_i) begin
      drop_q <= drop_q + IDX_W'(1);
    end
  end

  assign pol_o      = pol_q;
  assign prod_idx_o = prod_q;
  assign drop_cnt_o = drop_q;
endmodule

// File: rtl/rxc_mem.sv
module rxc_mem #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/rx_cmpl_gen.sv
module rx_cmpl_gen
  import rxc_pkg::*;
#(
  parameter int MIN_LG   = 5,
  parameter int MAX_LG   = 10,
  parameter int LG_W     = 4,
  parameter int IDX_W    = 16,
  parameter int IN_LEN_W = 16,
  localparam int ADDR_W  = MAX_LG
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frame_done_i,
  input  logic [IN_LEN_W-1:0] frame_len_i,
  input  logic                frame_mac_err_i,
  input  logic [CSUM_W-1:0]   frame_csum_i,
  input  logic [LG_W-1:0]     ring_lg_i,
  input  logic [IDX_W-1:0]    cons_idx_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [ENTRY_W-1:0]  rd_data_o,
  output logic                wr_en_o,
  output logic [ADDR_W-1:0]   wr_addr_o,
  output logic [ENTRY_W-1:0]  wr_data_o,
  output logic [IDX_W-1:0]    prod_idx_o,
  output logic [IDX_W-1:0]    drop_cnt_o,
  output logic                rx_event_o
);
  logic              accept, pol;
  logic [ADDR_W-1:0] slot;
  cmpl_entry_t       entry;

  logic               wr_en_q, evt_q;
  logic [ADDR_W-1:0]  wr_addr_q;
  logic [ENTRY_W-1:0] wr_data_q;

  rxc_ring_ctl #(
    .MIN_LG(MIN_LG), .MAX_LG(MAX_LG), .LG_W(LG_W), .IDX_W(IDX_W)
  ) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_done_i(frame_done_i),
    .ring_lg_i   (ring_lg_i),
    .cons_idx_i  (cons_idx_i),
    .accept_o    (accept),
    .slot_o      (slot),
    .pol_o       (pol),
    .prod_idx_o  (prod_idx_o),
    .drop_cnt_o  (drop_cnt_o)
  );

  rxc_pack #(.IN_LEN_W(IN_LEN_W)) u_pack (
    .len_i    (frame_len_i),
    .mac_err_i(frame_mac_err_i),
    .csum_i   (frame_csum_i),
    .pol_i    (pol),
    .entry_o  (entry)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      evt_q     <= 1'b0;
    end else begin
      wr_en_q <= accept;
      evt_q   <= wr_en_q;
      if (accept) begin
        wr_addr_q <= slot;
        wr_data_q <= entry;
      end
    end
  end

  rxc_mem #(.ADDR_W(ADDR_W), .DATA_W(ENTRY_W)) u_mem (
    .clk_i  (clk_i),
    .we_i   (wr_en_q),
    .waddr_i(wr_addr_q),
    .wdata_i(wr_data_q),
    .raddr_i(rd_addr_i),
    .rdata_o(rd_data_o)
  );

  assign wr_en_o    = wr_en_q;
  assign wr_addr_o  = wr_addr_q;
  assign wr_data_o  = wr_data_q;
  assign rx_event_o = evt_q;
endmodule

// File: rtl/rx_cmpl_gen_chk.sv
module rx_cmpl_gen_chk #(
  parameter int IDX_W   = 16,
  parameter int ENTRIES = 1024
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frame_done_i,
  input logic [IDX_W-1:0] cons_idx_i,
  input logic             wr_en_o,
  input logic [31:0]      wr_data_o,
  input logic [IDX_W-1:0] prod_idx_o,
  input logic [IDX_W-1:0] drop_cnt_o,
  input logic             rx_event_o
);
  AST_EVT_FOLLOWS_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> rx_event_o); // R8
  AST_EVT_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_event_o |-> $past(wr_en_o)); // R8
  AST_WR_HAS_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(frame_done_i)); // R7
  AST_PROD_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prod_idx_o != $past(prod_idx_o)) |-> (wr_en_o && prod_idx_o == IDX_W'($past(prod_idx_o) + 1'b1))); // R6
  AST_DROP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_cnt_o != $past(drop_cnt_o)) |-> ($past(frame_done_i) && !wr_en_o)); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (IDX_W'(prod_idx_o - $past(cons_idx_i)) <= IDX_W'(ENTRIES))); // R5
  AST_TRUNC_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_data_o[13]) |-> (wr_data_o[10:0] == 11'h7ff)); // R2
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_data_o[15:14] == 2'b00)); // R1
endmodule

bind rx_cmpl_gen rx_cmpl_gen_chk u_chk (.*);

// File: tb/rx_cmpl_gen_tb_top.sv
module rx_cmpl_gen_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        frame_done = 1'b0;
  logic [15:0] frame_len = '0;
  logic        frame_err = 1'b0;
  logic [15:0] frame_csum = '0;
  logic [3:0]  ring_lg = 4'd5;
  logic [15:0] cons_idx = '0;
  logic [9:0]  rd_addr = '0;
  logic [31:0] rd_data, wr_data;
  logic        wr_en, rx_event;
  logic [9:0]  wr_addr;
  logic [15:0] prod_idx, drop_cnt;

  rx_cmpl_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .frame_done_i(frame_done), .frame_len_i(frame_len),
    .frame_mac_err_i(frame_err), .frame_csum_i(frame_csum), .ring_lg_i(ring_lg),
    .cons_idx_i(cons_idx), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .wr_en_o(wr_en),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .prod_idx_o(prod_idx),
    .drop_cnt_o(drop_cnt), .rx_event_o(rx_event)
  );

  typedef struct { logic [9:0] addr; logic [31:0] data; } exp_t;
  exp_t exp_q[$];
  int n_chk = 0, n_bad = 0;

  logic [15:0] m_prod = '0, m_drop = '0;
  logic        m_pol = 1'b1;
  logic [31:0] m_mem [1024];
  logic [31:0] first_rec;
  logic        prev_wr = 1'b0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int eff_lg(int lg);
    if (lg < 5) return 5;
    if (lg > 10) return 10;
    return lg;
  endfunction

  // drive one frame at a negedge and update the reference model
  task automatic send(int len, bit err, logic [15:0] cs);
    int          sz;
    logic [15:0] occ;
    logic [9:0]  slot;
    logic [10:0] flen;
    bit          tr;
    exp_t        e;
    @(negedge clk);
    frame_done = 1'b1; frame_len = 16'(len); frame_err = err; frame_csum = cs;
    sz  = 1 << eff_lg(int'(ring_lg));
    occ = m_prod - cons_idx;
    if (int'(occ) >= sz) begin
      m_drop++;
    end else begin
      slot = 10'(int'(m_prod) % sz);
      tr   = len > 2047;
      flen = tr ? 11'h7ff : 11'(len);
      e.addr = slot;
      e.data = {cs, 2'b00, tr, err, m_pol, flen};
      exp_q.push_back(e);
      m_mem[slot] = e.data;
      if (int'(slot) == sz - 1) m_pol = ~m_pol;
      m_prod++;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frame_done = 1'b0;
    end
  endtask

  // monitor: scoreboard pop on each write, event pulse follows each write
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_event || prev_wr) check("R8 event pulse", 32'(rx_event), 32'(prev_wr));
      prev_wr = wr_en;
      if (wr_en) begin
        if (exp_q.size() == 0) begin
          check("R7 unexpected write", 32'(1), 32'(0));
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check("R3 write slot", 32'(wr_addr), 32'(e.addr));
          check("R1 R2 R4 record", wr_data, e.data);
        end
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 wr_en reset", 32'(wr_en), 0);
    check("R9 event reset", 32'(rx_event), 0);
    check("R9 prod reset", 32'(prod_idx), 0);
    check("R9 drop reset", 32'(drop_cnt), 0);
    rst_n = 1'b1;
    idle(2);

    // R1 R2 R10: back-to-back frames with varied fields
    send(64, 0, 16'h1234);
    first_rec = m_mem[0];
    send(1500, 1, 16'hbeef);
    send(2047, 0, 16'h0f0f);
    send(2048, 0, 16'ha5a5);
    send(3000, 1, 16'hffff);
    idle(3);
    check("R6 prod after 5", 32'(prod_idx), 32'(m_prod));

    // R5: fill a 32-entry ring, then overflow by two
    for (int i = 5; i < 32; i++) send(60 + i, i[0], 16'(i * 7));
    send(100, 0, 16'h0bad);
    send(101, 0, 16'h0bad);
    idle(3);
    check("R5 drop count", 32'(drop_cnt), 32'd2);
    check("R5 prod held at full", 32'(prod_idx), 32'd32);
    rd_addr = 10'd0; #1;
    check("R5 slot 0 untouched", rd_data, first_rec);
    rd_addr = 10'd31; #1;
    check("R7 slot 31 readable", rd_data, m_mem[31]);

    // R4: second pass writes valid bit 0, third pass back to 1
    cons_idx = 16'd32;
    for (int i = 0; i < 32; i++) send(200 + i, 0, 16'(i));
    idle(3);
    rd_addr = 10'd5; #1;
    check("R4 second pass valid=0", 32'(rd_data[11]), 32'd0);
    cons_idx = 16'd64;
    send(77, 0, 16'h7777);
    idle(3);
    rd_addr = 10'd0; #1;
    check("R4 third pass valid=1", 32'(rd_data[11]), 32'd1);

    // R3: log below range acts as 32 entries
    ring_lg = 4'd3;
    cons_idx = m_prod;
    for (int i = 0; i < 33; i++) send(300 + i, 0, 16'(i + 3));
    idle(3);
    check("R3 clamp low drop", 32'(drop_cnt), 32'd3);

    // R3: log above range acts as 1024 entries; occupancy 32 not full
    ring_lg = 4'd15;
    for (int i = 0; i < 3; i++) send(400 + i, 1, 16'(i + 9));
    idle(3);
    check("R3 clamp high no drop", 32'(drop_cnt), 32'd3);
    check("R6 prod after clamp", 32'(prod_idx), 32'(m_prod));

    // R6: run the producer index through its 16-bit wrap
    ring_lg = 4'd10;
    for (int i = 0; i < 65536; i++) begin
      if ((i % 512) == 0) begin
        idle(1);
        cons_idx = m_prod;
      end
      send(i % 2100, 0, 16'(i));
    end
    idle(4);
    check("R6 prod wrap", 32'(prod_idx), 32'(m_prod));
    check("R5 no drops while drained", 32'(drop_cnt), 32'(m_drop));
    check("R7 scoreboard drained", 32'(exp_q.size()), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule